// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit load/store RISC core. Software addresses sixteen registers by a 4-bit index. Index 13 is the stack pointer, index 14 the link register, index 15 the program counter, and indices 0 to 12 hold data. The core runs in one of seven processor modes, and the mode selects which physical copy of some of those indices an access reaches. Behind the sixteen indices sit 31 physical general registers and 6 status registers, 37 in all.

Two read ports are purely combinational, and one write port commits on the clock edge. A current status word holds the mode in its low five bits. Each exception mode also has one saved status word. Either status word can be written one byte field at a time under a 4-bit mask. An exception-entry strobe updates three things in a single cycle: it saves the current status, loads the return address into the target mode's link register, and switches to the target mode. The core's sequencing logic drives this block. Decode, arithmetic, memory traffic and exception vectoring all live outside it.

Top module: `bank_regfile`

## Requirements
- R1: After reset, every index reads zero in the reset mode, the current status word reads 0x00000013 (Supervisor), and the Supervisor saved status reads zero.
- R2: Both read ports return the addressed register combinationally. A write lands on the next clock edge, so a read of the same index in the write cycle returns the old value.
- R3: The mode is taken from current status bits 4:0, with these codes: 10000 User, 10001 FIQ, 10010 IRQ, 10011 Supervisor, 10111 Abort, 11011 Undefined, 11111 System. Any other code banks exactly as User.
- R4: FIQ mode has private copies of indices 8 to 14. Indices 0 to 7 and 15 are shared with User.
- R5: IRQ, Supervisor, Abort and Undefined each have private copies of indices 13 and 14 only. All other indices reach the User copies.
- R6: System mode reaches exactly the User registers.
- R7: A status write updates only the bytes whose mask bit is set: mask bit 0 selects bits 7:0, bit 1 selects bits 15:8, bit 2 selects bits 23:16, and bit 3 selects bits 31:24. A zero mask changes nothing.
- R8: In User, System or an unknown mode, the saved status output reads zero, and a saved status write changes no register.
- R9: An exception-entry strobe that names an exception mode does three things at the next edge: it copies the current status word into that mode's saved status, writes the return address into that mode's index 14, and sets status bits 4:0 to the target mode. In the same cycle it wins over a general write to the same physical register, and it causes any status write to be dropped.
- R10: An exception-entry strobe whose target is User, System or an unknown code has no effect.
- R11: A write that changes the mode field takes effect for banking from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | General register write index |
| wr_data_i | input | 32 | General register write data |
| psr_wr_en_i | input | 1 | Status write enable |
| psr_sel_saved_i | input | 1 | 1 writes the current mode's saved status, 0 writes the current status |
| psr_mask_i | input | 4 | Byte field mask for the status write |
| psr_wr_data_i | input | 32 | Status write data |
| exc_en_i | input | 1 | Exception-entry strobe |
| exc_mode_i | input | 5 | Exception target mode code |
| exc_ret_addr_i | input | 32 | Return address for the target link register |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status of the current mode, zero when the mode has none |

## Verification
Reads are combinational. The bench therefore sets an index and samples the data a short delay later in the same low clock phase, with no edge in between. General writes, status writes and exception entry all commit on one rising edge. Their results are sampled at the falling edge that follows. A mode change has a similar one-edge delay. Bank-dependent reads are checked once before that edge, where they must still show the old bank, and once after it. In the cycle that carries a write, the bench also samples the same index and expects the old value.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
  localparam int NUM_ARCH   = 16;
  localparam int NUM_PHYS   = 31;
  localparam int NUM_SAVED  = 5;
  localparam int PHYS_W     = $clog2(NUM_PHYS);
  localparam int SLOT_W     = $clog2(NUM_SAVED);
  localparam int FIQ_BASE   = 16;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  // System and unknown codes bank as User
  function automatic bank_e mode_to_bank(input logic [4:0] m);
    case (m)
      MODE_FIQ: return BANK_FIQ;
      MODE_IRQ: return BANK_IRQ;
      MODE_SVC: return BANK_SVC;
      MODE_ABT: return BANK_ABT;
      MODE_UND: return BANK_UND;
      default:  return BANK_USR;
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] shadow_base(input bank_e b);
    case (b)
      BANK_IRQ: return PHYS_W'(23);
      BANK_SVC: return PHYS_W'(25);
      BANK_ABT: return PHYS_W'(27);
      default:  return PHYS_W'(29);
    endcase
  endfunction
endpackage

// File: rtl/bank_rf_map.sv
module bank_rf_map
  import bank_rf_pkg::*;
(
  input  bank_e             bank_i,
  input  logic [3:0]        idx_i,
  output logic [PHYS_W-1:0] phys_o
);
  always_comb begin
    phys_o = PHYS_W'(idx_i);
    if (bank_i == BANK_FIQ && idx_i >= 4'd8 && idx_i <= 4'd14) begin
      phys_o = PHYS_W'(FIQ_BASE) + PHYS_W'(idx_i - 4'd8);
    end else if (bank_i != BANK_USR && bank_i != BANK_FIQ &&
                 (idx_i == 4'd13 || idx_i == 4'd14)) begin
      phys_o = shadow_base(bank_i) + PHYS_W'(~idx_i[0]);
    end
  end

  always_comb begin
    assert_phys_range_R5: assert (int'(phys_o) < NUM_PHYS)
      else $error("physical index out of range");
    assert_shared_low_R4: assert (idx_i >= 4'd8 || phys_o == PHYS_W'(idx_i))
      else $error("low index not shared");
    assert_shared_pc_R4: assert (idx_i != 4'd15 || phys_o == PHYS_W'(15))
      else $error("pc not shared");
  end
endmodule

// File: rtl/bank_rf_gpr.sv
module bank_rf_gpr
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = NUM_PHYS,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NRD-1:0][AW-1:0]    rd_addr_i,
  output logic [NRD-1:0][DATA_W-1:0] rd_data_o,
  input  logic                      wr_a_en_i,
  input  logic [AW-1:0]             wr_a_addr_i,
  input  logic [DATA_W-1:0]         wr_a_data_i,
  input  logic                      wr_b_en_i,   // priority port
  input  logic [AW-1:0]             wr_b_addr_i,
  input  logic [DATA_W-1:0]         wr_b_data_i
);
  logic [NREG-1:0][DATA_W-1:0] regs_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[r] <= '0;
      end else if (wr_b_en_i && wr_b_addr_i == AW'(r)) begin
        regs_q[r] <= wr_b_data_i;
      end else if (wr_a_en_i && wr_a_addr_i == AW'(r)) begin
        regs_q[r] <= wr_a_data_i;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = regs_q[rd_addr_i[p]];
  end

  assert_prio_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_b_en_i |=> regs_q[$past(wr_b_addr_i)] == $past(wr_b_data_i))
    else $error("priority write lost");

  assert_plain_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a_en_i && !(wr_b_en_i && wr_b_addr_i == wr_a_addr_i))
      |=> regs_q[$past(wr_a_addr_i)] == $past(wr_a_data_i))
    else $error("write not committed");
endmodule

// File: rtl/bank_rf_psr.sv
module bank_rf_psr
  import bank_rf_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [4:0]  RESET_MODE = MODE_SVC,
  localparam int         NFIELD     = DATA_W / 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                sel_saved_i,
  input  logic [NFIELD-1:0]   mask_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                cur_slot_vld_i,
  input  logic [SLOT_W-1:0]   cur_slot_i,
  input  logic                exc_i,
  input  logic [SLOT_W-1:0]   exc_slot_i,
  input  logic [4:0]          exc_mode_i,
  output logic [DATA_W-1:0]   cpsr_o,
  output logic [DATA_W-1:0]   spsr_o
);
  logic [DATA_W-1:0]                 cpsr_q;
  logic [NUM_SAVED-1:0][DATA_W-1:0]  saved_q;
  logic [DATA_W-1:0]                 merged_cur, merged_saved;

  function automatic logic [DATA_W-1:0] merge_fields(
    input logic [DATA_W-1:0] old_v, input logic [DATA_W-1:0] new_v,
    input logic [NFIELD-1:0] m);
    logic [DATA_W-1:0] res;
    res = old_v;
    for (int k = 0; k < NFIELD; k++) begin
      if (m[k]) res[8*k +: 8] = new_v[8*k +: 8];
    end
    return res;
  endfunction

  assign merged_cur   = merge_fields(cpsr_q, wr_data_i, mask_i);
  assign merged_saved = merge_fields(saved_q[cur_slot_i], wr_data_i, mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q  <= DATA_W'(RESET_MODE);
      saved_q <= '0;
    end else if (exc_i) begin
      cpsr_q[4:0]         <= exc_mode_i;
      saved_q[exc_slot_i] <= cpsr_q;
    end else if (wr_en_i) begin
      if (!sel_saved_i)         cpsr_q              <= merged_cur;
      else if (cur_slot_vld_i)  saved_q[cur_slot_i] <= merged_saved;
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = cur_slot_vld_i ? saved_q[cur_slot_i] : '0;

  assert_exc_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> cpsr_q[4:0] == $past(exc_mode_i))
    else $error("mode not switched on exception");

  assert_exc_save_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> saved_q[$past(exc_slot_i)] == $past(cpsr_q))
    else $error("status not saved on exception");

  assert_zero_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mask_i == '0 && !exc_i) |=> ($stable(cpsr_q) && $stable(saved_q)))
    else $error("zero mask changed status");

  assert_no_saved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_saved_i && !cur_slot_vld_i && !exc_i) |=> $stable(saved_q))
    else $error("saved status written without a slot");

  assert_top_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sel_saved_i && !exc_i && mask_i[NFIELD-1])
      |=> cpsr_q[DATA_W-1 -: 8] == $past(wr_data_i[DATA_W-1 -: 8]))
    else $error("flags byte not written");
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_rf_pkg::*;
#(
  parameter int         DATA_W     = 32,
  parameter logic [4:0] RESET_MODE = MODE_SVC,
  localparam int        NFIELD     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              psr_wr_en_i,
  input  logic              psr_sel_saved_i,
  input  logic [NFIELD-1:0] psr_mask_i,
  input  logic [DATA_W-1:0] psr_wr_data_i,
  input  logic              exc_en_i,
  input  logic [4:0]        exc_mode_i,
  input  logic [DATA_W-1:0] exc_ret_addr_i,
  output logic [DATA_W-1:0] cpsr_o,
  output logic [DATA_W-1:0] spsr_o
);
  localparam int NPORT = 3;  // read A, read B, write

  logic [DATA_W-1:0]              cpsr;
  bank_e                          cur_bank, exc_bank;
  logic                           exc_ok;
  logic [SLOT_W-1:0]              cur_slot, exc_slot;
  logic [NPORT-1:0][3:0]          port_idx;
  logic [NPORT-1:0][PHYS_W-1:0]   port_phys;
  logic [PHYS_W-1:0]              lr_phys;
  logic [1:0][PHYS_W-1:0]         rd_addr;
  logic [1:0][DATA_W-1:0]         rd_data;

  assign cur_bank = mode_to_bank(cpsr[4:0]);
  assign exc_bank = mode_to_bank(exc_mode_i);
  assign exc_ok   = exc_en_i && exc_bank != BANK_USR;
  assign cur_slot = SLOT_W'(cur_bank) - SLOT_W'(1);
  assign exc_slot = SLOT_W'(exc_bank) - SLOT_W'(1);

  assign port_idx = {wr_idx_i, rd_b_idx_i, rd_a_idx_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bank_rf_map i_map (
      .bank_i (cur_bank),
      .idx_i  (port_idx[p]),
      .phys_o (port_phys[p])
    );
  end

  bank_rf_map i_map_lr (
    .bank_i (exc_bank),
    .idx_i  (4'd14),
    .phys_o (lr_phys)
  );

  assign rd_addr = {port_phys[1], port_phys[0]};

  bank_rf_gpr #(.DATA_W(DATA_W), .NREG(NUM_PHYS), .NRD(2)) i_gpr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .wr_a_en_i   (wr_en_i),
    .wr_a_addr_i (port_phys[2]),
    .wr_a_data_i (wr_data_i),
    .wr_b_en_i   (exc_ok),
    .wr_b_addr_i (lr_phys),
    .wr_b_data_i (exc_ret_addr_i)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  bank_rf_psr #(.DATA_W(DATA_W), .RESET_MODE(RESET_MODE)) i_psr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (psr_wr_en_i),
    .sel_saved_i    (psr_sel_saved_i),
    .mask_i         (psr_mask_i),
    .wr_data_i      (psr_wr_data_i),
    .cur_slot_vld_i (cur_bank != BANK_USR),
    .cur_slot_i     (cur_slot),
    .exc_i          (exc_ok),
    .exc_slot_i     (exc_slot),
    .exc_mode_i     (exc_mode_i),
    .cpsr_o         (cpsr),
    .spsr_o         (spsr_o)
  );

  assign cpsr_o = cpsr;

  assert_bad_exc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && !exc_ok && !psr_wr_en_i) |=> $stable(cpsr_o))
    else $error("invalid exception target changed status");

  assert_lr_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_ok |=> (cpsr_o[4:0] == $past(exc_mode_i)))
    else $error("exception mode not visible");

  assert_user_saved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpsr_o[4:0] == MODE_USR || cpsr_o[4:0] == MODE_SYS) |-> spsr_o == '0)
    else $error("saved status visible in user/system");
endmodule

// File: tb/test_bank_regfile.sv
module test_bank_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, cpsr_o, spsr_o;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        psr_wr_en_i = 1'b0, psr_sel_saved_i = 1'b0;
  logic [3:0]  psr_mask_i = '0;
  logic [31:0] psr_wr_data_i = '0;
  logic        exc_en_i = 1'b0;
  logic [4:0]  exc_mode_i = '0;
  logic [31:0] exc_ret_addr_i = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bank_regfile i_bank_regfile (
    .clk_i, .rst_ni,
    .rd_a_idx_i, .rd_a_data_o, .rd_b_idx_i, .rd_b_data_o,
    .wr_en_i, .wr_idx_i, .wr_data_i,
    .psr_wr_en_i, .psr_sel_saved_i, .psr_mask_i, .psr_wr_data_i,
    .exc_en_i, .exc_mode_i, .exc_ret_addr_i,
    .cpsr_o, .spsr_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] v);
    rd_a_idx_i = idx;
    #1;
    v = rd_a_data_o;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic psr_wr(input logic sel, input logic [3:0] m, input logic [31:0] d);
    psr_wr_en_i = 1'b1; psr_sel_saved_i = sel; psr_mask_i = m; psr_wr_data_i = d;
    step();
    psr_wr_en_i = 1'b0;
  endtask

  task automatic set_mode(input logic [4:0] m);
    psr_wr(1'b0, 4'b0001, {24'h0, 3'b000, m});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), v);
      check($sformatf("R1 reset idx %0d", i), v, 32'h0);
    end
    check("R1 reset cpsr", cpsr_o, 32'h0000_0013);
    check("R1 reset spsr", spsr_o, 32'h0);
  endtask

  task automatic t_same_cycle();
    wr_en_i = 1'b1; wr_idx_i = 4'd3; wr_data_i = 32'hCAFE_0003;
    rd_a_idx_i = 4'd3; rd_b_idx_i = 4'd3;
    #1;
    check("R2 old value port A", rd_a_data_o, 32'h0);
    check("R2 old value port B", rd_b_data_o, 32'h0);
    step();
    wr_en_i = 1'b0;
    #1;
    check("R2 new value port A", rd_a_data_o, 32'hCAFE_0003);
    check("R2 new value port B", rd_b_data_o, 32'hCAFE_0003);
  endtask

  task automatic t_fiq_bank();
    logic [31:0] v;
    set_mode(5'b10000);
    wr(4'd0, 32'h100);
    wr(4'd7, 32'h107);
    for (int i = 8; i < 16; i++) wr(4'(i), 32'h100 + 32'(i));
    // mode write in flight: banking still User this cycle
    psr_wr_en_i = 1'b1; psr_sel_saved_i = 1'b0; psr_mask_i = 4'b0001;
    psr_wr_data_i = 32'h11;
    rd(4'd8, v);
    check("R11 old bank during mode write", v, 32'h108);
    step();
    psr_wr_en_i = 1'b0;
    rd(4'd8, v);   check("R11 FIQ r8 after switch", v, 32'h0);
    rd(4'd14, v);  check("R4 FIQ r14 private", v, 32'h0);
    rd(4'd0, v);   check("R4 FIQ r0 shared", v, 32'h100);
    rd(4'd7, v);   check("R4 FIQ r7 shared", v, 32'h107);
    rd(4'd15, v);  check("R4 FIQ r15 shared", v, 32'h10F);
    wr(4'd10, 32'hF10);
    rd(4'd10, v);  check("R4 FIQ r10 write", v, 32'hF10);
    set_mode(5'b10000);
    rd(4'd10, v);  check("R4 user r10 untouched", v, 32'h10A);
  endtask

  task automatic t_shadow_modes();
    logic [31:0] v;
    set_mode(5'b10010);
    rd(4'd12, v);  check("R5 IRQ r12 shared", v, 32'h10C);
    rd(4'd8, v);   check("R5 IRQ r8 shared", v, 32'h108);
    rd(4'd13, v);  check("R5 IRQ r13 private", v, 32'h0);
    wr(4'd13, 32'h1D13);
    set_mode(5'b10011);
    rd(4'd13, v);  check("R5 SVC r13 private", v, 32'h0);
    rd(4'd12, v);  check("R5 SVC r12 shared", v, 32'h10C);
    set_mode(5'b10111);
    rd(4'd13, v);  check("R5 ABT r13 private", v, 32'h0);
    set_mode(5'b11011);
    rd(4'd14, v);  check("R5 UND r14 private", v, 32'h0);
    set_mode(5'b10010);
    rd(4'd13, v);  check("R5 IRQ r13 kept", v, 32'h1D13);
  endtask

  task automatic t_system_unknown();
    logic [31:0] v;
    set_mode(5'b11111);
    rd(4'd13, v);  check("R6 SYS r13 is user", v, 32'h10D);
    rd(4'd14, v);  check("R6 SYS r14 is user", v, 32'h10E);
    check("R8 SYS spsr zero", spsr_o, 32'h0);
    psr_wr(1'b1, 4'b1111, 32'hFFFF_FFFF);
    check("R8 SYS spsr write ignored", spsr_o, 32'h0);
    check("R8 SYS cpsr unchanged", cpsr_o, 32'h0000_001F);
    set_mode(5'b10101);
    rd(4'd13, v);  check("R3 unknown mode banks as user", v, 32'h10D);
    check("R8 unknown spsr zero", spsr_o, 32'h0);
    set_mode(5'b10010);
    check("R8 IRQ spsr untouched", spsr_o, 32'h0);
  endtask

  task automatic t_psr_mask();
    psr_wr(1'b0, 4'b1000, 32'hA5FF_FFFF);
    check("R7 flags byte only", cpsr_o, 32'hA500_0012);
    psr_wr(1'b0, 4'b0110, 32'h1122_3344);
    check("R7 middle bytes", cpsr_o, 32'hA522_3312);
    psr_wr(1'b0, 4'b0000, 32'hFFFF_FFFF);
    check("R7 zero mask", cpsr_o, 32'hA522_3312);
    psr_wr(1'b1, 4'b0101, 32'hFFEE_DDCC);
    check("R7 saved mask", spsr_o, 32'h00EE_00CC);
  endtask

  task automatic t_exception();
    logic [31:0] v;
    set_mode(5'b10000);
    check("R9 pre-exception cpsr", cpsr_o, 32'hA522_3310);
    exc_en_i = 1'b1; exc_mode_i = 5'b10010; exc_ret_addr_i = 32'h8000_0004;
    wr_en_i = 1'b1; wr_idx_i = 4'd14; wr_data_i = 32'h0000_DEAD;
    psr_wr_en_i = 1'b1; psr_sel_saved_i = 1'b0; psr_mask_i = 4'hF; psr_wr_data_i = 32'h0;
    step();
    exc_en_i = 1'b0; wr_en_i = 1'b0; psr_wr_en_i = 1'b0;
    check("R9 mode set, status write dropped", cpsr_o, 32'hA522_3312);
    check("R9 status saved", spsr_o, 32'hA522_3310);
    rd(4'd14, v);  check("R9 IRQ link loaded", v, 32'h8000_0004);
    set_mode(5'b10000);
    rd(4'd14, v);  check("R9 user r14 took plain write", v, 32'h0000_DEAD);
    set_mode(5'b10011);
    exc_en_i = 1'b1; exc_mode_i = 5'b10011; exc_ret_addr_i = 32'h44;
    wr_en_i = 1'b1; wr_idx_i = 4'd14; wr_data_i = 32'h55;
    step();
    exc_en_i = 1'b0; wr_en_i = 1'b0;
    rd(4'd14, v);  check("R9 exception wins same register", v, 32'h44);
    check("R9 SVC saved status", spsr_o, 32'hA522_3313);
  endtask

  task automatic t_bad_exception();
    logic [31:0] v;
    exc_en_i = 1'b1; exc_mode_i = 5'b11111; exc_ret_addr_i = 32'h99;
    step();
    exc_mode_i = 5'b10000;
    step();
    exc_en_i = 1'b0;
    check("R10 cpsr unchanged", cpsr_o, 32'hA522_3313);
    check("R10 spsr unchanged", spsr_o, 32'hA522_3313);
    rd(4'd14, v);  check("R10 r14 unchanged", v, 32'h44);
    set_mode(5'b10000);
    rd(4'd14, v);  check("R10 user r14 unchanged", v, 32'h0000_DEAD);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_same_cycle();
    t_fiq_bank();
    t_shadow_modes();
    t_system_unknown();
    t_psr_mask();
    t_exception();
    t_bad_exception();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule